// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that software controls through a flat, word-wide register interface. Each pin can be an output or an input. Output values live in a data register, and software can also change them through two side registers. One side register raises the bits written as one and the other lowers them, so a single write changes some pins without disturbing the rest. Input pins pass through a two-stage synchronizer, and software reads the result from a read-only register.

Every pin also carries its own interrupt detector. Three configuration bits select the trigger for each pin: level or edge, which polarity, and whether both edges count. An edge event stays latched in a pending bit until software writes a one to that bit in the acknowledge register. A level-mode pin instead shows its live qualified level. The pending bits of pins that are enabled and not masked are ORed into one interrupt line for the whole port. Pull-control and debounce registers are plain storage only; pads and filtering are handled outside the block.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, every register clears to 0 on the clock edge. After reset, `pin_out`, `pin_oe` and `irq` are 0, and every register reads 0.
- R2: A write to offset 0x08 (direction) drives `pin_oe` from the next edge and can be read back. A bit of 1 means output and 0 means input. A write to offset 0x00 loads the output register, which drives `pin_out` and reads back at 0x00.
- R3: A write to offset 0x10 sets every output bit whose write-data bit is 1. A write to offset 0x14 clears every such bit. Bits written as 0 keep their value.
- R4: Offset 0x04 returns `pin_in` delayed by exactly two clock edges (a two-flop synchronizer), and writes to 0x04 are ignored.
- R5: When trigger-type bit (offset 0x34) = 0, polarity bit (0x3C) = 0 and both-edge bit (0x38) = 0, a rising edge latches the pin's bit in status (offset 0x24). The bit becomes readable three edges after the pin changes.
- R6: When trigger-type = 0, polarity = 1 and both-edge = 0, only a falling edge latches the status bit.
- R7: When trigger-type = 0 and both-edge = 1, rising and falling edges both latch the status bit, whatever the polarity bit holds.
- R8: When trigger-type = 1, the status bit shows the live synchronized level, inverted when polarity = 1. Nothing is latched.
- R9: Writing 1 to a bit of offset 0x30 clears that pin's latched edge status, and writing 0 leaves it unchanged. If an edge event arrives on the same edge as the clear, the event wins and the bit stays set.
- R10: Detection happens only on pins whose interrupt-enable bit (offset 0x20) is 1. A disabled pin never sets its status bit.
- R11: `irq` is the OR over all pins of status AND enable AND NOT mask (offset 0x2C; a mask bit of 1 blocks the pin). It follows status with no extra delay.
- R12: Pull enable (0x18), pull type (0x1C), debounce enable (0x40) and debounce prescale (0x44) are read/write storage with no effect on any pin.
- R13: Reads of unmapped offsets return 0. Writes to the status offset 0x24 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pad input values |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq | output | 1 | Aggregated port interrupt |

## Verification
A register write takes effect on the edge that samples `bus_wr`, so the bench reads back on the following falling edge. A pin change lands in the input register two edges later and in a latched edge status three edges later. A level status is due after two edges, and `irq` in the same cycle as status. The bench drives stimulus on a falling edge and waits exactly that many falling edges before it samples. It also samples one edge early to confirm the input register has not yet moved. The same-edge event/clear race is produced by issuing the acknowledge write on the falling edge just before the event edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 8;

    // Register byte offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFF_DOUT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DIN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SET    = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PULLEN = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_PULLTY = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ISTAT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_IMASK  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_IACK   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_ITYPE  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_IBOTH  = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_IPOL   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_DBEN   = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_DBPRE  = 8'h44;

    // Per-pin trigger selection
    typedef struct packed {
        logic lvl;   // 1: level sensitive, 0: edge sensitive
        logic low;   // 1: low level / falling edge
        logic both;  // edge mode only: any transition
    } trig_cfg_t;

    // Qualified trigger condition for one pin from current and previous sample
    function automatic logic trig_hit(trig_cfg_t cfg, logic cur, logic prv);
        logic r;
        if (cfg.lvl)
            r = cur ^ cfg.low;
        else if (cfg.both)
            r = cur ^ prv;
        else if (cfg.low)
            r = prv & ~cur;
        else
            r = cur & ~prv;
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_port_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] lvl_sel,
    input  logic [N-1:0] low_sel,
    input  logic [N-1:0] both_sel,
    input  logic [N-1:0] ack,
    output logic [N-1:0] status
);
    logic [N-1:0] prv;
    logic [N-1:0] held;
    logic [N-1:0] evt;
    logic [N-1:0] lvl_live;

    for (genvar i = 0; i < N; i++) begin : g_pin
        trig_cfg_t cfg;
        logic      hit;
        assign cfg         = '{lvl: lvl_sel[i], low: low_sel[i], both: both_sel[i]};
        assign hit         = trig_hit(cfg, cur[i], prv[i]);
        assign evt[i]      = enable[i] & ~lvl_sel[i] & hit;
        assign lvl_live[i] = enable[i] &  lvl_sel[i] & hit;
        assign status[i]   = lvl_sel[i] ? lvl_live[i] : held[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prv  <= '0;
            held <= '0;
        end else begin
            prv  <= cur;
            held <= (held & ~ack) | evt;
        end
    end

    // R9: acknowledged bit without a concurrent event is gone next cycle
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((held & $past(ack & ~evt)) == '0));

    // R10: a latched bit can only appear on a pin that was enabled
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((held & ~$past(held) & ~$past(enable)) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [N_PINS-1:0] dout;
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] pull_en;
        logic [N_PINS-1:0] pull_ty;
        logic [N_PINS-1:0] ien;
        logic [N_PINS-1:0] imask;
        logic [N_PINS-1:0] itype;
        logic [N_PINS-1:0] iboth;
        logic [N_PINS-1:0] ipol;
        logic [N_PINS-1:0] db_en;
        logic [N_PINS-1:0] db_pre;
    } regs_t;

    regs_t             rf;
    regs_t             rf_nxt;
    logic [N_PINS-1:0] din_sync;
    logic [N_PINS-1:0] istat;
    logic [N_PINS-1:0] ack_bits;

    gpio_sync #(.W(N_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (din_sync)
    );

    assign ack_bits = (bus_wr && bus_addr == OFF_IACK) ? bus_wdata : '0;

    gpio_irq_detect #(.N(N_PINS)) u_det (
        .clk      (clk),
        .rst      (rst),
        .cur      (din_sync),
        .enable   (rf.ien),
        .lvl_sel  (rf.itype),
        .low_sel  (rf.ipol),
        .both_sel (rf.iboth),
        .ack      (ack_bits),
        .status   (istat)
    );

    always_comb begin
        rf_nxt = rf;
        if (bus_wr) begin
            case (bus_addr)
                OFF_DOUT:   rf_nxt.dout    = bus_wdata;
                OFF_SET:    rf_nxt.dout    = rf.dout | bus_wdata;
                OFF_CLR:    rf_nxt.dout    = rf.dout & ~bus_wdata;
                OFF_DIR:    rf_nxt.dir     = bus_wdata;
                OFF_PULLEN: rf_nxt.pull_en = bus_wdata;
                OFF_PULLTY: rf_nxt.pull_ty = bus_wdata;
                OFF_IEN:    rf_nxt.ien     = bus_wdata;
                OFF_IMASK:  rf_nxt.imask   = bus_wdata;
                OFF_ITYPE:  rf_nxt.itype   = bus_wdata;
                OFF_IBOTH:  rf_nxt.iboth   = bus_wdata;
                OFF_IPOL:   rf_nxt.ipol    = bus_wdata;
                OFF_DBEN:   rf_nxt.db_en   = bus_wdata;
                OFF_DBPRE:  rf_nxt.db_pre  = bus_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rf <= '0;
        else     rf <= rf_nxt;
    end

    always_comb begin
        case (bus_addr)
            OFF_DOUT:   bus_rdata = rf.dout;
            OFF_DIN:    bus_rdata = din_sync;
            OFF_DIR:    bus_rdata = rf.dir;
            OFF_PULLEN: bus_rdata = rf.pull_en;
            OFF_PULLTY: bus_rdata = rf.pull_ty;
            OFF_IEN:    bus_rdata = rf.ien;
            OFF_ISTAT:  bus_rdata = istat;
            OFF_IMASK:  bus_rdata = rf.imask;
            OFF_ITYPE:  bus_rdata = rf.itype;
            OFF_IBOTH:  bus_rdata = rf.iboth;
            OFF_IPOL:   bus_rdata = rf.ipol;
            OFF_DBEN:   bus_rdata = rf.db_en;
            OFF_DBPRE:  bus_rdata = rf.db_pre;
            default:    bus_rdata = '0;
        endcase
    end

    assign pin_out = rf.dout;
    assign pin_oe  = rf.dir;
    assign irq     = |(istat & rf.ien & ~rf.imask);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0));

    assert_dir_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_DIR) |=> (pin_oe == $past(bus_wdata)));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    assert_blocked_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (rf.imask == '1 || rf.ien == '0) |-> !irq);

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] acc;
        tick(2);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        acc = 0;
        for (int a = 0; a < 'h48; a += 4) begin
            rd(a[7:0], v);
            acc |= v;
        end
        chk("R1 regs", acc, 0);

        // R2: direction and output register
        wr(8'h08, 32'hF0F0_1234);
        chk("R2 pin_oe", pin_oe, 32'hF0F0_1234);
        rd(8'h08, v); chk("R2 dir readback", v, 32'hF0F0_1234);
        wr(8'h00, 32'h0000_FFFF);
        chk("R2 pin_out", pin_out, 32'h0000_FFFF);
        rd(8'h00, v); chk("R2 dout readback", v, 32'h0000_FFFF);

        // R3: set and clear registers
        wr(8'h10, 32'hA5A5_0000);
        chk("R3 set", pin_out, 32'hA5A5_FFFF);
        wr(8'h14, 32'h8001_00FF);
        chk("R3 clear", pin_out, 32'h25A4_FF00);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        chk("R3 zero words", pin_out, 32'h25A4_FF00);

        // R4: two-edge input path
        pin_in = 32'h1357_9BDF;
        tick(1);
        rd(8'h04, v); chk("R4 one edge old", v, 0);
        tick(1);
        rd(8'h04, v); chk("R4 two edges", v, 32'h1357_9BDF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R4 write ignored", v, 32'h1357_9BDF);
        pin_in = 0;
        tick(3);

        // R5 R6 R7 R8 R11: sweep all trigger configurations
        for (int c = 0; c < 8; c++) begin
            int p;
            logic lv, lo, bo, e_rise, e_fall;
            string tag;
            p  = c * 4 + 1;
            lv = c[2]; lo = c[1]; bo = c[0];
            tag = lv ? "R8" : (bo ? "R7" : (lo ? "R6" : "R5"));
            wr(8'h34, 32'(lv) << p);
            wr(8'h3C, 32'(lo) << p);
            wr(8'h38, 32'(bo) << p);
            wr(8'h2C, 32'h0);
            wr(8'h20, 32'h1 << p);
            wr(8'h30, 32'hFFFF_FFFF);
            e_rise = lv ? ~lo : (bo | ~lo);
            e_fall = lv ? lo : (e_rise | bo | lo);
            pin_in[p] = 1'b1;
            tick(3);
            rd(8'h24, v); chk($sformatf("%s rise cfg%0d", tag, c), {31'b0, v[p]}, {31'b0, e_rise});
            chk($sformatf("R11 irq rise cfg%0d", c), {31'b0, irq}, {31'b0, e_rise});
            pin_in[p] = 1'b0;
            tick(3);
            rd(8'h24, v); chk($sformatf("%s fall cfg%0d", tag, c), {31'b0, v[p]}, {31'b0, e_fall});
            chk($sformatf("R11 irq fall cfg%0d", c), {31'b0, irq}, {31'b0, e_fall});
            wr(8'h2C, 32'h1 << p);
            chk($sformatf("R11 masked cfg%0d", c), {31'b0, irq}, 0);
            wr(8'h2C, 32'h0);
        end

        // R9: acknowledge behaviour on edge pin 3 (rising)
        wr(8'h34, 0); wr(8'h3C, 0); wr(8'h38, 0); wr(8'h2C, 0);
        wr(8'h20, 32'h8);
        wr(8'h30, 32'hFFFF_FFFF);
        pin_in[3] = 1'b1; tick(3);
        rd(8'h24, v); chk("R9 latched", v & 32'h8, 32'h8);
        pin_in[3] = 1'b0; tick(3);
        rd(8'h24, v); chk("R9 stays after level drops", v & 32'h8, 32'h8);
        wr(8'h30, 32'hFFFF_FFF7);
        rd(8'h24, v); chk("R9 zero bit no effect", v & 32'h8, 32'h8);
        wr(8'h30, 32'h8);
        rd(8'h24, v); chk("R9 cleared", v & 32'h8, 0);
        chk("R9 irq off", {31'b0, irq}, 0);
        // event and clear on the same edge: event wins
        pin_in[3] = 1'b1; tick(2);
        wr(8'h30, 32'h8);
        rd(8'h24, v); chk("R9 event beats clear", v & 32'h8, 32'h8);
        pin_in[3] = 1'b0; tick(3);
        wr(8'h30, 32'hFFFF_FFFF);

        // R10: disabled pin never latches
        wr(8'h20, 32'h0);
        pin_in[3] = 1'b1; tick(3);
        pin_in[3] = 1'b0; tick(3);
        rd(8'h24, v); chk("R10 no status", v & 32'h8, 0);
        chk("R10 no irq", {31'b0, irq}, 0);
        wr(8'h20, 32'h8);
        rd(8'h24, v); chk("R10 no stale status", v & 32'h8, 0);

        // R12: storage registers
        wr(8'h18, 32'hDEAD_BEEF);
        wr(8'h1C, 32'h0BAD_F00D);
        wr(8'h40, 32'h1234_5678);
        wr(8'h44, 32'h00C0_FFEE);
        rd(8'h18, v); chk("R12 pull en", v, 32'hDEAD_BEEF);
        rd(8'h1C, v); chk("R12 pull type", v, 32'h0BAD_F00D);
        rd(8'h40, v); chk("R12 debounce en", v, 32'h1234_5678);
        rd(8'h44, v); chk("R12 prescale", v, 32'h00C0_FFEE);
        chk("R12 no pin effect", pin_out ^ pin_oe, 32'h25A4_FF00 ^ 32'hF0F0_1234);

        // R13: unmapped reads, status write ignored
        rd(8'h0C, v); chk("R13 hole 0x0C", v, 0);
        rd(8'h28, v); chk("R13 hole 0x28", v, 0);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R13 status write ignored", v & 32'h8, 0);
        chk("R13 irq quiet", {31'b0, irq}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule